// File: doc/BRIEF.md
# CFI and ID query response formatter

This block supplies the read word for a flash bank while the bank answers identifier reads or common-flash-interface queries. The bank is made of one or more identical devices ganged side by side. For each read, the block turns the byte address on the bus into the index that a single device would see. It looks that index up in a small query table or in the two identifier values. It then copies the one-device answer into every device lane of the bank and assembles the word for the access width requested.

The bank width, the device width and the maximum width the device supports are all configuration inputs given as base-2 logarithms. A wide device can therefore run in byte mode, and narrow devices can share a wider bus. The query table starts out holding the three-character signature and is otherwise empty. It can be filled one byte at a time through an initialisation port. The answer is computed combinationally and registered once, so `rvalid` and `rdata` appear one clock after `rd_req`.

Top module: `qry_resp_fmt`

## Requirements
- R1: After reset `rvalid` and `rdata` are 0, table entries 0x10, 0x11 and 0x12 hold 0x51, 0x52 and 0x59, and every other table entry holds 0.
- R2: `rvalid` is high exactly in the cycle after a cycle with `rd_req` high. `rdata` changes only in the cycle after a request and otherwise holds its value.
- R3: The per-device index is the bus byte offset shifted right by `cfg_bank_lg + cfg_max_lg - cfg_dev_lg`.
- R4: In query mode (`rd_mode` = 1), an index of 82 (0x52) or more returns 0 for that device.
- R5: When `cfg_dev_lg` is below `cfg_max_lg` and `cfg_dev_lg` = 0 (byte mode), the table byte fills every byte of the bank. In query mode, when `cfg_dev_lg` is below `cfg_max_lg` and `cfg_dev_lg` is not 0, the answer is 0.
- R6: The one-device answer, 8<<`cfg_dev_lg` bits wide, is repeated in every device lane up to the bank width. A table byte in a lane wider than one byte sits in the lane's low byte and the lane's higher bytes are zero.
- R7: In ID mode (`rd_mode` = 0), the low 8 bits of the index select the answer: 0 gives `id_manuf`, 1 gives `id_part`, and any other value gives 0 (this includes 2 and 3). The 16-bit value is cut or zero-extended to the device lane.
- R8: When the access is wider than the bank, bank slice k is the query at byte offset `rd_addr + k*bank_width` and lands at bits `[8*bank_width*k +: 8*bank_width]`.
- R9: The access width is 1<<`rd_size` bytes, and an `rd_size` of 3 is treated as 2. The bytes of `rdata` above the access width are 0.
- R10: A configuration with any log value of 3, or with `cfg_dev_lg` greater than `cfg_bank_lg` or greater than `cfg_max_lg`, returns 0.
- R11: A cycle with `tbl_we` high writes `tbl_wdata` into table entry `tbl_waddr` when that index is below 82. Writes to index 82 or above change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_req | input | 1 | Read request for this cycle |
| rd_mode | input | 1 | 0 = identifier read, 1 = query-table read |
| rd_addr | input | AW | Bus byte offset |
| rd_size | input | 2 | log2 of the access width in bytes |
| cfg_bank_lg | input | 2 | log2 of the bank width in bytes |
| cfg_dev_lg | input | 2 | log2 of the device width in use |
| cfg_max_lg | input | 2 | log2 of the device's maximum width |
| id_manuf | input | 16 | Manufacturer identifier |
| id_part | input | 16 | Device identifier |
| tbl_we | input | 1 | Table initialisation write enable |
| tbl_waddr | input | 7 | Table entry index to write |
| tbl_wdata | input | 8 | Table byte to write |
| rvalid | output | 1 | Read data valid, one cycle after `rd_req` |
| rdata | output | 32 | Formatted read word |

## Verification
The bench targets the address scaling with the shift taken from each of several bank, device and maximum-width combinations. A wrong shift would return the neighbouring table entry, for example 0x52 in place of 0x51. It checks byte mode on a wide device, where zero padding in place of repetition would give 0x00000051 in place of 0x51515151, and also the unsupported narrow mode, which must return 0. Wide accesses over narrow banks are checked, since a slice order or step that is wrong scrambles the signature bytes. Further checks cover the table-size edge at 0x51 and 0x52, ID offsets 2, 3 and 0x100, which a decoder that is too wide or too narrow would get wrong, and an out-of-range table write that a missing bound check would let through.

// File: rtl/qrf_pkg.sv
`timescale 1ns/1ps
package qrf_pkg;
    localparam int QRF_DEPTH     = 82;
    localparam int QRF_IW        = 7;
    localparam int QRF_BUS_BYTES = 4;
    localparam int QRF_BUS_BITS  = QRF_BUS_BYTES * 8;
    localparam int QRF_ID_BITS   = 16;

    typedef enum logic {
        QRF_MODE_ID    = 1'b0,
        QRF_MODE_QUERY = 1'b1
    } qrf_mode_e;

    // Reset content of one table entry: signature bytes, zero elsewhere.
    function automatic logic [7:0] qrf_reset_byte(input int idx);
        case (idx)
            16'h10:  return 8'h51;
            16'h11:  return 8'h52;
            16'h12:  return 8'h59;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/qrf_table.sv
`timescale 1ns/1ps
module qrf_table
    import qrf_pkg::*;
#(
    parameter int DEPTH = QRF_DEPTH,
    parameter int IW    = QRF_IW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [IW-1:0]        waddr,
    input  logic [7:0]           wdata,
    output logic [DEPTH*8-1:0]   tbl_flat
);
    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];
    logic       wr_hit;

    assign wr_hit = we && (int'(waddr) < DEPTH);

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
            if (wr_hit && (int'(waddr) == i)) begin
                mem_d[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= qrf_reset_byte(i);
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_flat
            assign tbl_flat[g*8 +: 8] = mem_q[g];
        end
    endgenerate

    AST_TBL_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (int'(waddr) < DEPTH)) |=> (mem_q[$past(waddr)] == $past(wdata))); // R11
    AST_TBL_OOR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!we || (int'(waddr) >= DEPTH)) |=> $stable(tbl_flat)); // R11
endmodule

// File: rtl/qrf_slice.sv
`timescale 1ns/1ps
module qrf_slice
    import qrf_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DEPTH = QRF_DEPTH
) (
    input  logic [AW-1:0]          off,
    input  logic                   mode,
    input  logic [1:0]             bank_lg,
    input  logic [1:0]             dev_lg,
    input  logic [1:0]             max_lg,
    input  logic [DEPTH*8-1:0]     tbl_flat,
    input  logic [QRF_ID_BITS-1:0] id_manuf,
    input  logic [QRF_ID_BITS-1:0] id_part,
    output logic [QRF_BUS_BITS-1:0] bank_word
);
    logic [2:0]              shamt;
    logic [AW-1:0]           idx;
    logic                    cfg_ok;
    logic                    narrow;
    logic                    unsup;
    logic                    hit;
    logic [7:0]              tbyte;
    logic [QRF_BUS_BITS-1:0] dev_resp;
    logic [QRF_BUS_BITS-1:0] lane;
    logic [1:0]              lane_sel;

    always_comb begin
        shamt  = {1'b0, bank_lg} + {1'b0, max_lg} - {1'b0, dev_lg};
        idx    = off >> shamt;
        cfg_ok = (bank_lg != 2'd3) && (dev_lg != 2'd3) && (max_lg != 2'd3)
              && (dev_lg <= bank_lg) && (dev_lg <= max_lg);
        narrow = (dev_lg != max_lg);
        unsup  = narrow && (dev_lg != 2'd0);
        hit    = (idx < AW'(DEPTH));

        tbyte = 8'h00;
        for (int i = 0; i < DEPTH; i++) begin
            if (idx == AW'(i)) begin
                tbyte = tbl_flat[i*8 +: 8];
            end
        end

        dev_resp = '0;
        if (mode == QRF_MODE_QUERY) begin
            if (hit && !unsup) begin
                dev_resp[7:0] = tbyte;
                if (narrow) begin
                    // byte mode: repeat over the full native width
                    for (int j = 1; j < QRF_BUS_BYTES; j++) begin
                        if (j < (1 << max_lg)) begin
                            dev_resp[j*8 +: 8] = tbyte;
                        end
                    end
                end
            end
        end else begin
            case (idx[7:0])
                8'd0:    dev_resp[QRF_ID_BITS-1:0] = id_manuf;
                8'd1:    dev_resp[QRF_ID_BITS-1:0] = id_part;
                default: dev_resp = '0;
            endcase
        end

        // keep only the device lane
        lane = '0;
        for (int j = 0; j < QRF_BUS_BYTES; j++) begin
            if (j < (1 << dev_lg)) begin
                lane[j*8 +: 8] = dev_resp[j*8 +: 8];
            end
        end

        // replicate the lane across the bank
        bank_word = '0;
        for (int j = 0; j < QRF_BUS_BYTES; j++) begin
            lane_sel = 2'(j) & 2'((1 << dev_lg) - 1);
            if (cfg_ok && (j < (1 << bank_lg))) begin
                bank_word[j*8 +: 8] = lane[lane_sel*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/qry_resp_fmt.sv
`timescale 1ns/1ps
module qry_resp_fmt
    import qrf_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DEPTH = QRF_DEPTH
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd_req,
    input  logic                    rd_mode,
    input  logic [AW-1:0]           rd_addr,
    input  logic [1:0]              rd_size,
    input  logic [1:0]              cfg_bank_lg,
    input  logic [1:0]              cfg_dev_lg,
    input  logic [1:0]              cfg_max_lg,
    input  logic [QRF_ID_BITS-1:0]  id_manuf,
    input  logic [QRF_ID_BITS-1:0]  id_part,
    input  logic                    tbl_we,
    input  logic [QRF_IW-1:0]       tbl_waddr,
    input  logic [7:0]              tbl_wdata,
    output logic                    rvalid,
    output logic [QRF_BUS_BITS-1:0] rdata
);
    localparam int NSLICE = QRF_BUS_BYTES;

    typedef struct packed {
        logic                    rvalid;
        logic [QRF_BUS_BITS-1:0] rdata;
    } st_t;

    st_t st_d, st_q;

    logic [DEPTH*8-1:0]      tbl_flat;
    logic [QRF_BUS_BITS-1:0] slice_word [NSLICE];
    logic [1:0]              size_eff;
    logic [QRF_BUS_BITS-1:0] word;
    logic [1:0]              sidx;
    logic [1:0]              bsel;

    qrf_table #(.DEPTH(DEPTH), .IW(QRF_IW)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (tbl_we),
        .waddr    (tbl_waddr),
        .wdata    (tbl_wdata),
        .tbl_flat (tbl_flat)
    );

    generate
        for (genvar k = 0; k < NSLICE; k++) begin : g_slice
            logic [AW-1:0] slice_off;
            assign slice_off = rd_addr + (AW'(k) << cfg_bank_lg);
            qrf_slice #(.AW(AW), .DEPTH(DEPTH)) u_slice (
                .off       (slice_off),
                .mode      (rd_mode),
                .bank_lg   (cfg_bank_lg),
                .dev_lg    (cfg_dev_lg),
                .max_lg    (cfg_max_lg),
                .tbl_flat  (tbl_flat),
                .id_manuf  (id_manuf),
                .id_part   (id_part),
                .bank_word (slice_word[k])
            );
        end
    endgenerate

    always_comb begin
        size_eff = (rd_size == 2'd3) ? 2'd2 : rd_size;
        word     = '0;
        for (int j = 0; j < QRF_BUS_BYTES; j++) begin
            sidx = 2'(j >> cfg_bank_lg);
            bsel = 2'(j) & 2'((1 << cfg_bank_lg) - 1);
            if (j < (1 << size_eff)) begin
                word[j*8 +: 8] = slice_word[sidx][bsel*8 +: 8];
            end
        end

        st_d        = st_q;
        st_d.rvalid = rd_req;
        if (rd_req) begin
            st_d.rdata = word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rvalid = st_q.rvalid;
    assign rdata  = st_q.rdata;

    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rvalid); // R2
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rvalid); // R2
    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(rdata)); // R2
    AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_size == 2'd0) |=> (rdata[31:8] == '0)); // R9
    AST_BAD_CFG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && (cfg_bank_lg == 2'd3 || cfg_dev_lg > cfg_bank_lg)) |=> (rdata == '0)); // R10
    AST_QRY_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_mode && rd_size == 2'd0 && cfg_bank_lg == 2'd0 && cfg_dev_lg == 2'd0
         && cfg_max_lg == 2'd0 && rd_addr >= AW'(DEPTH)) |=> (rdata == '0)); // R4
endmodule

// File: tb/sim_qry_resp_fmt.sv
`timescale 1ns/1ps
module sim_qry_resp_fmt;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_req = 1'b0;
    logic        rd_mode = 1'b0;
    logic [15:0] rd_addr = '0;
    logic [1:0]  rd_size = '0;
    logic [1:0]  cfg_bank_lg = '0;
    logic [1:0]  cfg_dev_lg = '0;
    logic [1:0]  cfg_max_lg = '0;
    logic [15:0] id_manuf = 16'h1234;
    logic [15:0] id_part = 16'hABCD;
    logic        tbl_we = 1'b0;
    logic [6:0]  tbl_waddr = '0;
    logic [7:0]  tbl_wdata = '0;
    logic        rvalid;
    logic [31:0] rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    qry_resp_fmt u0 (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_mode(rd_mode),
        .rd_addr(rd_addr), .rd_size(rd_size), .cfg_bank_lg(cfg_bank_lg),
        .cfg_dev_lg(cfg_dev_lg), .cfg_max_lg(cfg_max_lg), .id_manuf(id_manuf),
        .id_part(id_part), .tbl_we(tbl_we), .tbl_waddr(tbl_waddr),
        .tbl_wdata(tbl_wdata), .rvalid(rvalid), .rdata(rdata)
    );

    // {req[3:0], mode, size[1:0], bank[1:0], dev[1:0], max[1:0], addr[15:0], exp[31:0]}
    localparam int NV = 27;
    localparam logic [60:0] VEC [NV] = '{
        {4'd3,  1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 16'h0010, 32'h00000051}, // R3
        {4'd3,  1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 16'h0011, 32'h00000052}, // R3
        {4'd3,  1'b1, 2'd1, 2'd1, 2'd1, 2'd1, 16'h0020, 32'h00000051}, // R3
        {4'd6,  1'b1, 2'd2, 2'd2, 2'd1, 2'd1, 16'h0040, 32'h00510051}, // R6
        {4'd5,  1'b1, 2'd2, 2'd2, 2'd0, 2'd1, 16'h0080, 32'h51515151}, // R5
        {4'd5,  1'b1, 2'd2, 2'd2, 2'd1, 2'd2, 16'h0080, 32'h00000000}, // R5
        {4'd4,  1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 16'h0052, 32'h00000000}, // R4
        {4'd11, 1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 16'h0051, 32'h0000005E}, // R11
        {4'd8,  1'b1, 2'd2, 2'd0, 2'd0, 2'd0, 16'h0010, 32'h00595251}, // R8
        {4'd8,  1'b1, 2'd2, 2'd1, 2'd1, 2'd1, 16'h0020, 32'h00520051}, // R8
        {4'd9,  1'b1, 2'd0, 2'd2, 2'd2, 2'd2, 16'h0041, 32'h00000051}, // R9
        {4'd9,  1'b1, 2'd3, 2'd0, 2'd0, 2'd0, 16'h0010, 32'h00595251}, // R9
        {4'd9,  1'b1, 2'd1, 2'd2, 2'd2, 2'd2, 16'h0040, 32'h00000051}, // R9
        {4'd7,  1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 16'h0000, 32'h00000034}, // R7
        {4'd7,  1'b0, 2'd1, 2'd1, 2'd1, 2'd1, 16'h0002, 32'h0000ABCD}, // R7
        {4'd7,  1'b0, 2'd1, 2'd1, 2'd1, 2'd1, 16'h0004, 32'h00000000}, // R7
        {4'd7,  1'b0, 2'd1, 2'd1, 2'd1, 2'd1, 16'h0006, 32'h00000000}, // R7
        {4'd8,  1'b0, 2'd2, 2'd1, 2'd0, 2'd0, 16'h0000, 32'hCDCD3434}, // R8
        {4'd7,  1'b0, 2'd2, 2'd2, 2'd2, 2'd2, 16'h0400, 32'h00001234}, // R7
        {4'd6,  1'b0, 2'd2, 2'd2, 2'd1, 2'd1, 16'h0004, 32'hABCDABCD}, // R6
        {4'd10, 1'b0, 2'd0, 2'd0, 2'd1, 2'd1, 16'h0000, 32'h00000000}, // R10
        {4'd10, 1'b1, 2'd1, 2'd1, 2'd2, 2'd2, 16'h0040, 32'h00000000}, // R10
        {4'd5,  1'b1, 2'd0, 2'd0, 2'd0, 2'd2, 16'h0040, 32'h00000051}, // R5
        {4'd10, 1'b1, 2'd0, 2'd3, 2'd0, 2'd0, 16'h0010, 32'h00000000}, // R10
        {4'd11, 1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 16'h0000, 32'h000000A0}, // R11
        {4'd11, 1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 16'h0020, 32'h000000C3}, // R11
        {4'd4,  1'b1, 2'd2, 2'd0, 2'd0, 2'd0, 16'h0050, 32'h00005E00}  // R4
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_read(input string tag, input logic mode, input logic [1:0] size,
                           input logic [1:0] b, input logic [1:0] d, input logic [1:0] m,
                           input logic [15:0] addr, input logic [31:0] exp);
        @(negedge clk);
        rd_req = 1'b1; rd_mode = mode; rd_size = size;
        cfg_bank_lg = b; cfg_dev_lg = d; cfg_max_lg = m; rd_addr = addr;
        @(negedge clk);
        rd_req = 1'b0;
        check({tag, " rvalid"}, {31'b0, rvalid}, 32'd1);
        check(tag, rdata, exp);
    endtask

    task automatic tbl_write(input logic [6:0] a, input logic [7:0] v);
        @(negedge clk);
        tbl_we = 1'b1; tbl_waddr = a; tbl_wdata = v;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 rvalid at reset", {31'b0, rvalid}, 32'd0);
        check("R1 rdata at reset", rdata, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {31'b0, rvalid}, 32'd0);
        do_read("R1 signature Y", 1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 16'h0012, 32'h59);
        do_read("R1 empty entry", 1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 16'h0000, 32'h00);
        do_read("R1 empty entry 0x51", 1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 16'h0051, 32'h00);

        // hold behaviour with no request
        @(negedge clk);
        check("R2 rvalid low when idle", {31'b0, rvalid}, 32'd0);
        check("R2 rdata held when idle", rdata, 32'h00);
        do_read("R2 fresh read", 1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 16'h0010, 32'h51);
        rd_addr = 16'h0011;
        @(negedge clk);
        check("R2 rdata held after address change", rdata, 32'h51);
        check("R2 rvalid low after address change", {31'b0, rvalid}, 32'd0);

        tbl_write(7'h00, 8'hA0);
        tbl_write(7'h20, 8'hC3);
        tbl_write(7'h51, 8'h5E);
        tbl_write(7'h52, 8'h77); // beyond the table: ignored (R11)
        tbl_write(7'h7F, 8'h99); // beyond the table: ignored (R11)

        for (int i = 0; i < NV; i++) begin
            string t;
            t = $sformatf("R%0d vec%0d", int'(VEC[i][60:57]), i);
            do_read(t, VEC[i][56], VEC[i][55:54], VEC[i][53:52], VEC[i][51:50],
                    VEC[i][49:48], VEC[i][47:32], VEC[i][31:0]);
        end

        // directed corner: second reset restores the signature and clears writes
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 rdata cleared by reset", rdata, 32'd0);
        rst_n = 1'b1;
        do_read("R1 written entry cleared", 1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 16'h0000, 32'h00);
        do_read("R1 signature after reset", 1'b1, 2'd2, 2'd0, 2'd0, 2'd0, 16'h0010, 32'h00595251);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule